// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block models a synchronous static RAM whose data bus never needs an idle cycle when traffic changes direction. Each command is captured on a rising clock edge. A write command names its address at once, but its data follows one edge later in flow-through mode and two edges later in pipelined mode. Because of this late write, a read and a write can be issued on consecutive edges in any order. A small internal array holds 36-bit words, arranged as four 9-bit bytes, and each byte has its own active-low write enable.

A static mode pin selects the variant. Flow-through mode has no output register, so read data appears in the cycle right after the command edge. Pipelined mode adds one output register, so read data appears one cycle later. A burst is started by a load command and continued by advance commands. Each advance steps the two low address bits in either linear or interleaved order, and the burst wraps after four beats.

Three chip enables select the device. An asynchronous output enable and a sleep input can both silence the output at any time. Sleep also blocks new accesses from starting.

Top module: `nbt_sram`

## Requirements
- R1: In flow-through mode (`pipe_mode`=0), the data of a write is taken from `din` at the first rising edge after the edge that captured the write command.
- R2: In pipelined mode (`pipe_mode`=1), the data of a write is taken from `din` at the second rising edge after the command edge.
- R3: In flow-through mode, a read captured at edge k drives `dout` with `dout_en`=1 during the cycle that follows edge k.
- R4: In pipelined mode, a read captured at edge k drives `dout` with `dout_en`=1 during the cycle that follows edge k+1.
- R5: Reads and writes may be issued on consecutive edges in any order, and each read returns the contents left by every write issued before it in command order.
- R6: A load is `adv`=0 while the device is selected. It starts a burst at `addr`. When `burst_ilv`=0, each later `adv`=1 edge adds the beat count to the two low address bits modulo 4, keeps the upper bits, reuses the direction of the load, and returns to the start address after the fourth beat.
- R7: When `burst_ilv`=1, the low two address bits of an advance beat are the start bits XOR the beat count.
- R8: `bw_n[i]`=0 writes bits [9i+8:9i] of the word. Bytes whose `bw_n` bit is 1 keep their old value.
- R9: A command is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. An `adv`=0 edge without selection is a deselect: no write happens, no read data is driven, and any burst in progress ends.
- R10: `oe_n`=1 forces `dout_en` low at once, in any cycle.
- R11: While `sleep`=1, no access starts at an edge, any burst in progress ends, and `dout_en` is low.
- R12: A read issued while an earlier write to the same address still waits for its data returns that write's data in the enabled bytes and the older contents in the others.
- R13: `dout_en` is never high in a cycle that does not present read data, and this includes every cycle in which write data is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 selects pipelined mode, 0 selects flow-through mode; held static |
| burst_ilv | input | 1 | 1 selects interleaved burst order, 0 selects linear order |
| addr | input | 6 | Word address for a load |
| adv | input | 1 | 1 continues the current burst, 0 loads a new command |
| we | input | 1 | On a load, 1 selects write and 0 selects read |
| bw_n | input | 4 | Active-low byte write enables |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request; blocks accesses and silences output |
| din | input | 36 | Late write data |
| dout | output | 36 | Read data |
| dout_en | output | 1 | High when `dout` carries read data that may be driven |

## Verification
The assertions assume that `pipe_mode` changes only while reset is held. This is what lets a read or write command be tied to the output cycle one or two edges later. They also take `oe_n` and `sleep` to be steady around the sampling edge. The stimulus meets both conditions. It changes mode and burst order only inside a reset sequence, and it changes every input at the falling edge. Sleep is raised only after the pipeline has drained, so no read result falls inside a sleep window.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    localparam int BYTE_W  = 9;
    localparam int NBYTES  = 4;
    localparam int ADDR_W  = 6;
    localparam int BURST_W = 2;
    localparam int DATA_W  = BYTE_W * NBYTES;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [NBYTES-1:0] ben_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // One captured access as it moves toward its late data
    typedef struct packed {
        logic  vld;
        logic  wr;
        addr_t addr;
        ben_t  be;
    } cmd_t;

    function automatic logic [BURST_W-1:0] beat_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input order_e             ord
    );
        return (ord == ORD_INTERLEAVE) ? (start ^ beat) : (start + beat);
    endfunction

    function automatic word_t merge_bytes(
        input word_t old_w,
        input word_t new_w,
        input ben_t  be
    );
        word_t r;
        r = old_w;
        for (int i = 0; i < NBYTES; i++) begin
            if (be[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/nbt_cmd_seq.sv
module nbt_cmd_seq
    import nbt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  addr_t  ext_addr,
    input  logic   adv,
    input  logic   we,
    input  logic   selected,
    input  logic   sleep,
    input  order_e ord,
    input  ben_t   be,
    output cmd_t   c1,
    output cmd_t   c2
);
    addr_t              base_q;
    logic [BURST_W-1:0] beat_q;
    logic               wr_q;
    logic               act_q;

    logic               load;
    logic               cont;
    logic [BURST_W-1:0] beat_nx;
    cmd_t               c1_nx;

    always_comb begin
        load    = !adv && selected && !sleep;
        cont    = adv && act_q && !sleep;
        beat_nx = beat_q + 1'b1;
        c1_nx    = '0;
        c1_nx.be = be;
        if (load) begin
            c1_nx.vld  = 1'b1;
            c1_nx.wr   = we;
            c1_nx.addr = ext_addr;
        end else if (cont) begin
            c1_nx.vld  = 1'b1;
            c1_nx.wr   = wr_q;
            c1_nx.addr = {base_q[ADDR_W-1:BURST_W],
                          beat_offset(base_q[BURST_W-1:0], beat_nx, ord)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            wr_q   <= 1'b0;
            act_q  <= 1'b0;
            c1     <= '0;
            c2     <= '0;
        end else begin
            c1 <= c1_nx;
            c2 <= c1;
            if (load) begin
                base_q <= ext_addr;
                beat_q <= '0;
                wr_q   <= we;
                act_q  <= 1'b1;
            end else if (cont) begin
                beat_q <= beat_nx;
            end else begin
                act_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nbt_store.sv
module nbt_store
    import nbt_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  addr_t waddr,
    input  word_t wdata,
    input  ben_t  be,
    input  addr_t raddr,
    output word_t rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= merge_bytes(mem[waddr], wdata, be);
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nbt_rd_path.sv
module nbt_rd_path
    import nbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pipe,
    input  logic  rd_now,
    input  logic  hit,
    input  ben_t  hit_be,
    input  word_t arr_rd,
    input  word_t din,
    input  logic  oe_n,
    input  logic  sleep,
    output word_t dout,
    output logic  dout_en
);
    word_t fwd_word;
    word_t q_dat;
    logic  q_vld;
    logic  data_vld;

    // per-byte bypass of the write whose data lands on this edge
    for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
        assign fwd_word[b*BYTE_W +: BYTE_W] = (hit && hit_be[b]) ?
            din[b*BYTE_W +: BYTE_W] : arr_rd[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
            q_dat <= '0;
        end else begin
            q_vld <= rd_now;
            q_dat <= fwd_word;
        end
    end

    assign data_vld = pipe ? q_vld : rd_now;
    assign dout     = pipe ? q_dat : arr_rd;
    assign dout_en  = data_vld && !oe_n && !sleep;
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
    import nbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv,
    input  logic              we,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    cmd_t  c1;
    cmd_t  c2;
    cmd_t  wcmd;
    word_t arr_rd;
    logic  selected;
    logic  fwd_hit;

    assign selected = !ce1_n && ce2 && !ce3_n;

    nbt_cmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .ext_addr (addr),
        .adv      (adv),
        .we       (we),
        .selected (selected),
        .sleep    (sleep),
        .ord      (order_e'(burst_ilv)),
        .be       (~bw_n),
        .c1       (c1),
        .c2       (c2)
    );

    // single late write uses stage 1, double late write uses stage 2
    assign wcmd    = pipe_mode ? c2 : c1;
    assign fwd_hit = pipe_mode && c2.vld && c2.wr && (c2.addr == c1.addr);

    nbt_store u_store (
        .clk   (clk),
        .wr_en (wcmd.vld && wcmd.wr),
        .waddr (wcmd.addr),
        .wdata (din),
        .be    (wcmd.be),
        .raddr (c1.addr),
        .rdata (arr_rd)
    );

    nbt_rd_path u_rd (
        .clk     (clk),
        .rst     (rst),
        .pipe    (pipe_mode),
        .rd_now  (c1.vld && !c1.wr),
        .hit     (fwd_hit),
        .hit_be  (c2.be),
        .arr_rd  (arr_rd),
        .din     (din),
        .oe_n    (oe_n),
        .sleep   (sleep),
        .dout    (dout),
        .dout_en (dout_en)
    );
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk (
    input logic clk,
    input logic rst,
    input logic pipe_mode,
    input logic adv,
    input logic we,
    input logic ce1_n,
    input logic ce2,
    input logic ce3_n,
    input logic oe_n,
    input logic sleep,
    input logic dout_en
);
    logic sel_c;
    logic ld_wr;
    logic ld_rd;
    logic desel;

    assign sel_c = !ce1_n && ce2 && !ce3_n;
    assign ld_wr = !adv && sel_c && we && !sleep;
    assign ld_rd = !adv && sel_c && !we && !sleep;
    assign desel = !adv && !sel_c;

    p_oe_off_r10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_en);

    p_sleep_off_r11: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_en);

    p_flow_wr_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && ld_wr) |=> !dout_en);

    p_pipe_wr_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && ld_wr) |=> ##1 !dout_en);

    p_flow_desel_r9: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && desel) |=> !dout_en);

    p_pipe_desel_r9: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && desel) |=> ##1 !dout_en);

    p_flow_rd_lat_r3: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && ld_rd) |=> (dout_en == (!oe_n && !sleep)));

    p_pipe_rd_lat_r4: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && ld_rd) |=> ##1 (dout_en == (!oe_n && !sleep)));
endmodule

bind nbt_sram nbt_sram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pipe_mode (pipe_mode),
    .adv       (adv),
    .we        (we),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dout_en   (dout_en)
);

// File: tb/sim_nbt_sram.sv
module sim_nbt_sram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pipe_mode = 1'b0;
    logic        burst_ilv = 1'b0;
    logic [5:0]  addr = '0;
    logic        adv = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  bw_n = 4'hF;
    logic        ce1_n = 1'b1;
    logic        ce2 = 1'b0;
    logic        ce3_n = 1'b1;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_en;

    always #5 clk = ~clk;

    nbt_sram u0 (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .addr(addr), .adv(adv), .we(we), .bw_n(bw_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n), .sleep(sleep),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    int          cur = 0;
    logic        vq  [16];
    logic [35:0] dq  [16];
    string       tq  [16];
    logic        wv  [16];
    logic [35:0] wdq [16];
    logic [35:0] model [64];
    logic [5:0]  b_base;
    logic [1:0]  b_cnt;
    logic        b_wr;
    logic        b_act;
    bit          probe_oe = 0;
    bit          slp = 0;

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock of stimulus: check this cycle's output, then drive the next command
    task automatic step(input bit adv_i, input bit we_i, input logic [5:0] a,
                        input logic [3:0] bwn, input logic [35:0] wd, input bit sel_i,
                        input string tag);
        int s;
        bit acc;
        bit wr;
        logic [5:0] ea;
        s = cur % 16;
        if (vq[s]) begin
            if (probe_oe) begin
                oe_n = 1'b1; #1;
                chk(dout_en === 1'b0, "R10 oe_n high silences output", {35'd0, dout_en}, 36'd0);
                oe_n = 1'b0; #1;
            end
            chk(dout_en === 1'b1 && dout === dq[s], tq[s], dout, dq[s]);
        end else begin
            chk(dout_en === 1'b0, slp ? "R11 no output while asleep" : "R13 no output without read",
                {35'd0, dout_en}, 36'd0);
        end
        vq[s] = 1'b0;
        din   = wv[s] ? wdq[s] : 36'hA5A5A5A5A;
        wv[s] = 1'b0;
        adv   = adv_i;
        we    = we_i;
        addr  = a;
        bw_n  = bwn;
        sleep = slp;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        if (!sel_i) begin
            case (cur % 3)
                0: ce1_n = 1'b1;
                1: ce2   = 1'b0;
                default: ce3_n = 1'b1;
            endcase
        end
        acc = 0; wr = 0; ea = '0;
        if (!slp && !adv_i && sel_i) begin
            b_base = a; b_cnt = 2'd0; b_wr = we_i; b_act = 1'b1;
            acc = 1; wr = we_i; ea = a;
        end else if (!slp && adv_i && b_act) begin
            b_cnt = b_cnt + 2'd1;
            ea = {b_base[5:2], burst_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            acc = 1; wr = b_wr;
        end else begin
            b_act = 1'b0;
        end
        if (acc && wr) begin
            for (int i = 0; i < 4; i++)
                if (!bwn[i]) model[ea][i*9 +: 9] = wd[i*9 +: 9];
            wv[(cur + (pipe_mode ? 2 : 1)) % 16]  = 1'b1;
            wdq[(cur + (pipe_mode ? 2 : 1)) % 16] = wd;
        end
        if (acc && !wr) begin
            vq[(cur + (pipe_mode ? 2 : 1)) % 16] = 1'b1;
            dq[(cur + (pipe_mode ? 2 : 1)) % 16] = model[ea];
            tq[(cur + (pipe_mode ? 2 : 1)) % 16] = tag;
        end
        @(negedge clk);
        cur++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 6'd0, 4'hF, 36'd0, 0, "idle");
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] bwn, input logic [35:0] d);
        step(0, 1, a, bwn, d, 1, "write");
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        step(0, 0, a, 4'hF, 36'd0, 1, tag);
    endtask

    task automatic do_reset(input bit p, input bit o);
        rst = 1'b1; pipe_mode = p; burst_ilv = o;
        adv = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; oe_n = 0; sleep = 0; slp = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin vq[i] = 0; wv[i] = 0; end
        b_act = 0; cur = 0;
        chk(dout_en === 1'b0, "R13 reset state", {35'd0, dout_en}, 36'd0);
    endtask

    task automatic t_basic;
        string tg;
        tg = pipe_mode ? "R2 R4 R5 latency/back-to-back" : "R1 R3 R5 latency/back-to-back";
        for (int i = 0; i < 4; i++) wr(6'(i), 4'h0, 36'h100000000 + 36'(i * 36'h11111));
        rd(6'd0, tg); wr(6'd4, 4'h0, 36'h0DEADBEEF); rd(6'd1, tg);
        wr(6'd5, 4'h0, 36'h987654321); rd(6'd4, tg); rd(6'd5, tg);
        wr(6'd2, 4'h0, 36'h555555555); rd(6'd2, tg); rd(6'd3, tg);
        idle(3);
    endtask

    task automatic t_fwd;
        wr(6'd10, 4'h0, 36'hFEDCBA987);
        wr(6'd10, 4'b0101, 36'h123456789);
        rd(6'd10, "R12 merged pending write");
        rd(6'd10, "R12 merged pending write again");
        wr(6'd11, 4'h0, 36'h0000000FF); rd(6'd11, "R12 read right after write");
        idle(3);
    endtask

    task automatic t_bytes;
        wr(6'd20, 4'h0, 36'hFFFFFFFFF);
        idle(3);
        for (int b = 0; b < 4; b++) begin
            wr(6'd20, ~(4'b1 << b), 36'h000000000);
            idle(3);
            rd(6'd20, "R8 single byte write");
            idle(3);
        end
        wr(6'd21, 4'h0, 36'h111111111); idle(2);
        wr(6'd21, 4'b1010, 36'h2AAAAAAAA); idle(2);
        rd(6'd21, "R8 two byte write");
        idle(3);
    endtask

    task automatic t_burst;
        string tg;
        tg = burst_ilv ? "R7 interleaved burst" : "R6 linear burst";
        wr(6'd6, 4'h0, 36'h0000000A0);
        step(1, 0, 6'd0, 4'h0, 36'h0000000A1, 1, "bw");
        step(1, 0, 6'd0, 4'h0, 36'h0000000A2, 1, "bw");
        step(1, 0, 6'd0, 4'h0, 36'h0000000A3, 1, "bw");
        rd(6'd5, tg);
        for (int i = 0; i < 4; i++) step(1, 1, 6'd0, 4'hF, 36'd0, 1, tg);
        rd(6'd7, tg);
        for (int i = 0; i < 3; i++) step(1, 1, 6'd0, 4'hF, 36'd0, 1, tg);
        idle(3);
    endtask

    task automatic t_desel;
        wr(6'd30, 4'h0, 36'h333333333);
        step(0, 1, 6'd30, 4'h0, 36'h0BADBADBA, 0, "R9 deselected write");
        step(0, 0, 6'd30, 4'hF, 36'd0, 0, "R9 deselected read");
        step(1, 0, 6'd0, 4'hF, 36'd0, 1, "R9 advance after deselect");
        rd(6'd30, "R9 deselected write ignored");
        step(0, 0, 6'd0, 4'hF, 36'd0, 0, "R9 deselect ends burst");
        step(1, 0, 6'd0, 4'hF, 36'd0, 1, "R9 advance after deselect");
        idle(3);
    endtask

    task automatic t_oe;
        wr(6'd40, 4'h0, 36'h404040404);
        probe_oe = 1;
        rd(6'd40, "R10 read with oe probe");
        idle(3);
        probe_oe = 0;
    endtask

    task automatic t_sleep;
        wr(6'd50, 4'h0, 36'h505050505);
        idle(3);
        slp = 1;
        wr(6'd50, 4'h0, 36'h0FFFF0000);
        rd(6'd50, "R11 read during sleep");
        step(1, 0, 6'd0, 4'hF, 36'd0, 1, "R11 advance during sleep");
        slp = 0;
        idle(3);
        rd(6'd50, "R11 sleep write ignored");
        idle(3);
    endtask

    initial begin
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            for (int o = 0; o < 2; o++) begin
                do_reset(p[0], o[0]);
                t_basic; t_fwd; t_bytes; t_burst; t_desel; t_oe; t_sleep;
            end
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule